// File: doc/BRIEF.md
# Instruction-Field Register Select for a Single-Bus Datapath

This block holds the thirty-two 32-bit general-purpose registers of a datapath that moves all operands over one shared internal bus. It does not take a register number from a dedicated address port. Instead it reads the register number straight out of the instruction word. The word holds three 5-bit register fields: a destination field, a base/source field and a second source field. The sequencer raises one field enable per step. That field goes through its own 5-to-32 decoder, and the three decoder outputs are ORed into a one-hot select across the register array.

On the same step, a drive strobe puts the selected register onto the bus output and a load strobe writes the bus input into the selected register at the next rising clock edge. A base-address strobe supports effective-address arithmetic for memory operations. When it is raised with the base field enabled and that field reads zero, the bus carries the constant zero instead of register 0. In every other case register 0 is an ordinary register.

Top module: `gpr_field_select`

## Requirements
- R1: After reset, every one of the 32 registers reads back as 0.
- R2: With only the destination enable high, the register numbered by instruction bits 26..22 is the one driven or loaded.
- R3: With only the base enable high, the register numbered by instruction bits 21..17 is the one driven or loaded.
- R4: With only the second-source enable high, the register numbered by instruction bits 16..12 is the one driven or loaded.
- R5: While the drive strobe is high, the bus output equals the selected register in the same cycle and the bus-valid output is high.
- R6: While the load strobe is high, the selected register takes the bus input at the next rising edge, and every other register keeps its value.
- R7: When the base-address strobe, the base enable and a zero base field (bits 21..17 = 0) coincide with the drive strobe, the bus output is 0 whatever register 0 holds.
- R8: With the base-address strobe low, or with register 0 chosen through the destination or second-source field, register 0 drives its stored contents.
- R9: While the drive strobe is low, the bus output is 0 and the bus-valid output is low.
- R10: With no field enable high, no register is selected: the load strobe changes nothing, and the drive strobe gives a bus output of 0.
- R11: The opcode bits 31..27 have no effect on which register is selected.
- R12: At most one field enable may be high in a cycle. With one enable high, the other two fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| instr_i | input | 32 | Instruction word that holds the three register fields |
| fld_a_en_i | input | 1 | Enables the destination field (bits 26..22) |
| fld_b_en_i | input | 1 | Enables the base/source field (bits 21..17) |
| fld_c_en_i | input | 1 | Enables the second-source field (bits 16..12) |
| drive_i | input | 1 | Puts the selected register on the bus output |
| load_i | input | 1 | Writes the bus input into the selected register |
| base_zero_i | input | 1 | Makes a zero base field read as constant 0 |
| bus_i | input | 32 | Value arriving from the internal bus |
| bus_o | output | 32 | Value this block places on the internal bus |
| bus_vld_o | output | 1 | High while bus_o carries a driven value |

## Verification
Drive results are combinational. The bus output and the valid flag follow the fields and strobes within the same cycle. A load goes through one register and becomes visible on the first read issued after the next rising edge. The reset release goes through two synchronizer flops, so the registers are usable from the third edge after release. The bench applies every stimulus at a falling edge and samples 2 ns later, well before the next rising edge. It checks each written value with a separate read in a later cycle, so no check depends on the order of processes at a clock edge.

// File: rtl/gprsel_pkg.sv
package gprsel_pkg;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_INSTR_W = 32;
  localparam int unsigned DEF_FIELD_W = 5;
  localparam int unsigned DEF_A_LSB   = 22;
  localparam int unsigned DEF_B_LSB   = 17;
  localparam int unsigned DEF_C_LSB   = 12;
  localparam int unsigned NUM_FIELDS  = 3;

  typedef enum logic [1:0] {
    FLD_DEST = 2'd0,
    FLD_BASE = 2'd1,
    FLD_SRC2 = 2'd2
  } fld_e;
endpackage

// File: rtl/gprsel_rst_sync.sv
module gprsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/gprsel_dec.sv
module gprsel_dec #(
  parameter  int unsigned IN_W  = 5,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic             en_i,
  input  logic [IN_W-1:0]  code_i,
  output logic [OUT_N-1:0] hot_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign hot_o[i] = en_i && (code_i == IN_W'(i));
  end
endmodule

// File: rtl/gprsel_select.sv
module gprsel_select
  import gprsel_pkg::*;
#(
  parameter  int unsigned INSTR_W = DEF_INSTR_W,
  parameter  int unsigned FIELD_W = DEF_FIELD_W,
  parameter  int unsigned A_LSB   = DEF_A_LSB,
  parameter  int unsigned B_LSB   = DEF_B_LSB,
  parameter  int unsigned C_LSB   = DEF_C_LSB,
  localparam int unsigned NREGS   = 1 << FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               a_en_i,
  input  logic               b_en_i,
  input  logic               c_en_i,
  input  logic               base_zero_i,
  output logic [NREGS-1:0]   sel_o,
  output logic               zero_o
);
  logic [FIELD_W-1:0] fld   [NUM_FIELDS];
  logic               fld_en[NUM_FIELDS];
  logic [NREGS-1:0]   hot   [NUM_FIELDS];

  assign fld[FLD_DEST]    = instr_i[A_LSB +: FIELD_W];
  assign fld[FLD_BASE]    = instr_i[B_LSB +: FIELD_W];
  assign fld[FLD_SRC2]    = instr_i[C_LSB +: FIELD_W];
  assign fld_en[FLD_DEST] = a_en_i;
  assign fld_en[FLD_BASE] = b_en_i;
  assign fld_en[FLD_SRC2] = c_en_i;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_dec
    gprsel_dec #(.IN_W(FIELD_W)) dec_i (
      .en_i  (fld_en[k]),
      .code_i(fld[k]),
      .hot_o (hot[k])
    );
  end

  always_comb begin
    sel_o = '0;
    for (int k = 0; k < NUM_FIELDS; k++) sel_o = sel_o | hot[k];
  end

  assign zero_o = base_zero_i && b_en_i && (fld[FLD_BASE] == '0);

  // R12
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_en_i, b_en_i, c_en_i}));

  // R2
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({a_en_i, b_en_i, c_en_i}) == 1) |-> $onehot(sel_o));

  // R10
  no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_en_i || b_en_i || c_en_i) |-> (sel_o == '0));
endmodule

// File: rtl/gprsel_regbank.sv
module gprsel_regbank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREGS-1:0]  sel_i,
  input  logic              zero_i,
  input  logic              load_i,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o
);
  logic [DATA_W-1:0] reg_q [NREGS];
  logic [DATA_W-1:0] reg_d [NREGS];
  logic [NREGS-1:0]  wr_en;
  logic [DATA_W-1:0] rd_val;

  assign wr_en = load_i ? sel_i : '0;

  always_comb begin
    for (int i = 0; i < NREGS; i++) begin
      reg_d[i] = wr_en[i] ? bus_i : reg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) reg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) reg_q[i] <= reg_d[i];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (sel_i[i] && !((i == 0) && zero_i)) rd_val = rd_val | reg_q[i];
    end
  end

  assign bus_o = drive_i ? rd_val : '0;

  for (genvar i = 0; i < NREGS; i++) begin : g_chk
    // R6
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && sel_i[i]) |=> (reg_q[i] == $past(bus_i)));
    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && sel_i[i]) |=> $stable(reg_q[i]));
  end
endmodule

// File: rtl/gpr_field_select.sv
module gpr_field_select
  import gprsel_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned INSTR_W = DEF_INSTR_W,
  parameter int unsigned FIELD_W = DEF_FIELD_W,
  parameter int unsigned A_LSB   = DEF_A_LSB,
  parameter int unsigned B_LSB   = DEF_B_LSB,
  parameter int unsigned C_LSB   = DEF_C_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               fld_a_en_i,
  input  logic               fld_b_en_i,
  input  logic               fld_c_en_i,
  input  logic               drive_i,
  input  logic               load_i,
  input  logic               base_zero_i,
  input  logic [DATA_W-1:0]  bus_i,
  output logic [DATA_W-1:0]  bus_o,
  output logic               bus_vld_o
);
  localparam int unsigned NREGS = 1 << FIELD_W;

  logic             rst_n_sync;
  logic [NREGS-1:0] sel;
  logic             zero_force;

  gprsel_rst_sync rst_sync_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_n_sync_o(rst_n_sync)
  );

  gprsel_select #(
    .INSTR_W(INSTR_W), .FIELD_W(FIELD_W),
    .A_LSB(A_LSB), .B_LSB(B_LSB), .C_LSB(C_LSB)
  ) select_i (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .instr_i    (instr_i),
    .a_en_i     (fld_a_en_i),
    .b_en_i     (fld_b_en_i),
    .c_en_i     (fld_c_en_i),
    .base_zero_i(base_zero_i),
    .sel_o      (sel),
    .zero_o     (zero_force)
  );

  gprsel_regbank #(.DATA_W(DATA_W), .NREGS(NREGS)) bank_i (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .sel_i  (sel),
    .zero_i (zero_force),
    .load_i (load_i),
    .drive_i(drive_i),
    .bus_i  (bus_i),
    .bus_o  (bus_o)
  );

  assign bus_vld_o = drive_i;

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !drive_i |-> (bus_o == '0 && !bus_vld_o));

  // R7
  base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (drive_i && base_zero_i && fld_b_en_i && instr_i[B_LSB +: FIELD_W] == '0)
      |-> (bus_o == '0));
endmodule

// File: tb/gpr_field_select_tb_top.sv
module gpr_field_select_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        a_en, b_en, c_en, drive, load, bz;
  logic [31:0] bus_in;
  logic [31:0] bus_out;
  logic        bus_vld;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  gpr_field_select dut_i (
    .clk(clk), .rst_n(rst_n), .instr_i(instr),
    .fld_a_en_i(a_en), .fld_b_en_i(b_en), .fld_c_en_i(c_en),
    .drive_i(drive), .load_i(load), .base_zero_i(bz),
    .bus_i(bus_in), .bus_o(bus_out), .bus_vld_o(bus_vld)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] patt(int i);
    return {8'(i), 8'(~i), 16'h5A00 + 16'(i)};
  endfunction

  // Put idx in field f; fill the other two fields with different numbers.
  function automatic logic [31:0] mkins(int f, int idx, logic [4:0] op);
    logic [4:0] a, b, c;
    a = 5'(idx + 9); b = 5'(idx + 17); c = 5'(idx + 25);
    if (f == 0) a = 5'(idx);
    if (f == 1) b = 5'(idx);
    if (f == 2) c = 5'(idx);
    return {op, a, b, c, 12'hABC};
  endfunction

  task automatic idle();
    a_en = 0; b_en = 0; c_en = 0; drive = 0; load = 0; bz = 0;
  endtask

  task automatic do_write(int f, int idx, logic [31:0] val);
    @(negedge clk);
    idle();
    instr = mkins(f, idx, 5'h0);
    a_en = (f == 0); b_en = (f == 1); c_en = (f == 2);
    load = 1; bus_in = val;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic do_read(int f, int idx, logic zb, logic [4:0] op, output logic [31:0] v);
    @(negedge clk);
    idle();
    instr = mkins(f, idx, op);
    a_en = (f == 0); b_en = (f == 1); c_en = (f == 2);
    bz = zb; drive = 1;
    #2 v = bus_out;
    n_cmp++;
    if (bus_vld !== 1'b1) begin
      n_bad++;
      $display("FAIL R5: actual valid %0b expected 1", bus_vld);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      do_read(0, i, 0, 5'h0, v);
      check("R1 reset value", v, 32'h0);
    end
  endtask

  task automatic t_fields();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) do_write(2, i, patt(i)); // R4 load through second-source field
    for (int i = 0; i < 32; i++) begin
      do_read(0, i, 0, 5'h0, v); check("R2 dest field read", v, patt(i));
      do_read(1, i, 0, 5'h0, v); check("R3 base field read", v, patt(i));
      do_read(2, i, 0, 5'h0, v); check("R4 src2 field read", v, patt(i));
    end
  endtask

  task automatic t_load_isolation();
    logic [31:0] v;
    do_write(0, 5, 32'hDEADBEEF);
    do_read(2, 5, 0, 5'h0, v); check("R6 written reg", v, 32'hDEADBEEF);
    do_read(2, 4, 0, 5'h0, v); check("R6 neighbour below", v, patt(4));
    do_read(2, 6, 0, 5'h0, v); check("R6 neighbour above", v, patt(6));
    do_read(0, 14, 0, 5'h0, v); check("R6 untouched other field reg", v, patt(14));
  endtask

  task automatic t_idle();
    logic [31:0] v;
    @(negedge clk); idle(); instr = mkins(0, 7, 5'h0); a_en = 1;
    #2 check("R9 bus idle", bus_out, 32'h0);
    check("R9 valid idle", {31'h0, bus_vld}, 32'h0);
    @(negedge clk); idle(); instr = mkins(0, 7, 5'h0);
    load = 1; bus_in = 32'h12345678;
    @(posedge clk); #1 idle();
    do_read(0, 7, 0, 5'h0, v); check("R10 load without enable", v, patt(7));
    @(negedge clk); idle(); instr = mkins(0, 7, 5'h0); drive = 1;
    #2 check("R10 drive without enable", bus_out, 32'h0);
    idle();
  endtask

  task automatic t_base_zero();
    logic [31:0] v;
    do_write(0, 0, 32'hCAFE0001);
    do_read(1, 0, 1, 5'h0, v); check("R7 zero base reads 0", v, 32'h0);
    do_read(1, 0, 0, 5'h0, v); check("R8 base strobe low reads R0", v, 32'hCAFE0001);
    do_read(0, 0, 1, 5'h0, v); check("R8 dest field R0 with strobe", v, 32'hCAFE0001);
    do_read(2, 0, 1, 5'h0, v); check("R8 src2 field R0 with strobe", v, 32'hCAFE0001);
    do_read(1, 3, 1, 5'h0, v); check("R7 nonzero base unaffected", v, patt(3));
  endtask

  task automatic t_opcode();
    logic [31:0] v;
    for (int op = 0; op < 32; op += 7) begin
      do_read(1, 9, 0, 5'(op), v); check("R11 opcode ignored", v, patt(9));
    end
  endtask

  task automatic t_exclusive();
    logic [31:0] v;
    @(negedge clk); idle();
    instr = {5'h1F, 5'd1, 5'd2, 5'd3, 12'h0};
    drive = 1; a_en = 1;
    #2 check("R12 only dest field used", bus_out, patt(1));
    @(negedge clk); a_en = 0; b_en = 1;
    #2 check("R12 only base field used", bus_out, patt(2));
    @(negedge clk); b_en = 0; c_en = 1;
    #2 check("R12 only src2 field used", bus_out, patt(3));
    idle();
    v = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(); instr = 32'h0; bus_in = 32'h0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    t_reset();
    t_fields();
    t_load_isolation();
    t_idle();
    t_base_zero();
    t_opcode();
    t_exclusive();
    finish_run();
  end
endmodule